// File: doc/BRIEF.md
# Address Error and Privilege Checker

This block screens each instruction fetch and data access before it reaches memory. Each request carries a virtual address, an access kind (fetch, load or store), an access size (byte, halfword or word) and the three privilege bits of the status state: the user-mode bit, the exception-level bit and the error-level bit. The checker decides whether the access must raise an address error. An access raises one if its address is not aligned to its size, or if it reaches the kernel half of the address space while the processor is in user mode.

A reported error appears one clock after the request on a valid/code pair that feeds the exception controller. On the same edge the faulting address is captured in a bad-address register. That register keeps its value until the next reported error, so a handler can read it after entry. Translation, bus errors and the memory access itself are handled elsewhere.

Top module: `aerr_checker`

## Requirements
- R1: While rst_ni is low, and on the first edge after it is released, exc_valid_o is 0, exc_code_o is 0 and badvaddr_o is 0.
- R2: A load or store of size word (size 2) or of the reserved size 3, whose address has bits [1:0] not equal to 00, raises an error.
- R3: A halfword access (size 1) raises a misalignment error only when address bit 0 is 1. A byte access (size 0) never raises a misalignment error.
- R4: User mode holds only when um=1, exl=0 and erl=0. In user mode, any access with address bit 31 set raises an error. In kernel mode, bit 31 never causes an error.
- R5: A reported error carries code 4 for fetches (kind 0) and loads (kind 1), and code 5 for stores (kind 2).
- R6: badvaddr_o takes the request address on the edge that reports an error. It keeps its previous value after any cycle with no request, or with a request that has no error.
- R7: exc_valid_o is 1 in the cycle after an erroring request with req_valid_i=1, and 0 in the cycle after a request without error or a cycle with req_valid_i=0.
- R8: A fetch is always checked for word alignment, whatever req_size_i says. Access kind 3 is reserved and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present this cycle |
| req_addr_i | input | 32 | Virtual address of the access |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| priv_um_i | input | 1 | User-mode status bit |
| priv_exl_i | input | 1 | Exception-level status bit |
| priv_erl_i | input | 1 | Error-level status bit |
| exc_valid_o | output | 1 | Address error reported |
| exc_code_o | output | 5 | Exception code of the reported error |
| badvaddr_o | output | 32 | Last faulting virtual address |

## Verification
The hardest cases combine several conditions at once. One is a misaligned access to a kernel address, made with um=1 while exl or erl hides user mode. The code must still follow the access kind, and the segment check must stay silent. Another is an erroring address offered with req_valid_i low, which must leave the bad-address register alone. The stimulus reaches both by sweeping every combination of privilege bits, kind, size, address bit 31 and the two low address bits. Each valid request is followed by an invalid one that carries a changed address.

// File: rtl/aerr_pkg.sv
package aerr_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam logic [CODE_W-1:0] EXC_ADEL = CODE_W'(4);
  localparam logic [CODE_W-1:0] EXC_ADES = CODE_W'(5);
endpackage

// File: rtl/aerr_priv_decode.sv
module aerr_priv_decode (
  input  logic um_i,
  input  logic exl_i,
  input  logic erl_i,
  output logic user_o
);
  // either level bit forces kernel mode
  assign user_o = um_i & ~exl_i & ~erl_i;
endmodule

// File: rtl/aerr_align_chk.sv
module aerr_align_chk
  import aerr_pkg::*;
(
  input  logic [1:0] addr_lo_i,
  input  acc_kind_e  kind_i,
  input  acc_size_e  size_i,
  output logic       mis_o
);
  logic [1:0] mask;

  always_comb begin
    mask = 2'b00;
    unique case (kind_i)
      ACC_FETCH: mask = 2'b11;
      ACC_NONE:  mask = 2'b00;
      default: begin
        unique case (size_i)
          SZ_BYTE: mask = 2'b00;
          SZ_HALF: mask = 2'b01;
          default: mask = 2'b11;
        endcase
      end
    endcase
  end

  assign mis_o = |(addr_lo_i & mask);
endmodule

// File: rtl/aerr_seg_chk.sv
module aerr_seg_chk #(
  parameter int ADDR_W   = 32,
  parameter int KSEG_BIT = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              user_i,
  input  logic              active_i,
  output logic              seg_err_o
);
  logic kseg;

  generate
    if (KSEG_BIT >= 0 && KSEG_BIT < ADDR_W) begin : g_kbit
      assign kseg = addr_i[KSEG_BIT];
    end else begin : g_nokbit
      assign kseg = 1'b0;
    end
  endgenerate

  assign seg_err_o = active_i & user_i & kseg;
endmodule

// File: rtl/aerr_checker.sv
module aerr_checker
  import aerr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_size_i,
  input  logic              priv_um_i,
  input  logic              priv_exl_i,
  input  logic              priv_erl_i,
  output logic              exc_valid_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [ADDR_W-1:0] badvaddr_o
);
  localparam int KSEG_BIT = ADDR_W - 1;

  acc_kind_e kind;
  acc_size_e size;
  logic user_w, mis_w, seg_w, err_w, report_w;
  logic [CODE_W-1:0] code_w;

  assign kind = acc_kind_e'(req_kind_i);
  assign size = acc_size_e'(req_size_i);

  aerr_priv_decode u_priv (
    .um_i   (priv_um_i),
    .exl_i  (priv_exl_i),
    .erl_i  (priv_erl_i),
    .user_o (user_w)
  );

  aerr_align_chk u_align (
    .addr_lo_i (req_addr_i[1:0]),
    .kind_i    (kind),
    .size_i    (size),
    .mis_o     (mis_w)
  );

  aerr_seg_chk #(.ADDR_W(ADDR_W), .KSEG_BIT(KSEG_BIT)) u_seg (
    .addr_i    (req_addr_i),
    .user_i    (user_w),
    .active_i  (kind != ACC_NONE),
    .seg_err_o (seg_w)
  );

  assign err_w    = mis_w | seg_w;
  assign report_w = req_valid_i & err_w;
  assign code_w   = (kind == ACC_STORE) ? EXC_ADES : EXC_ADEL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_o <= 1'b0;
      exc_code_o  <= '0;
      badvaddr_o  <= '0;
    end else begin
      exc_valid_o <= report_w;
      if (report_w) begin
        exc_code_o <= code_w;
        badvaddr_o <= req_addr_i;
      end
    end
  end

  // R3
  byte_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size == SZ_BYTE && kind != ACC_FETCH) |-> !mis_w);

  // R4
  kernel_no_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_w |-> !seg_w);

  // R5
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (exc_code_o == EXC_ADEL || exc_code_o == EXC_ADES));

  // R7
  valid_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !exc_valid_o);

  // R6
  bad_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_w |=> badvaddr_o == $past(req_addr_i));

  // R6
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(badvaddr_o));
endmodule

// File: tb/aerr_checker_bench.sv
`timescale 1ns/1ps
module aerr_checker_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind, req_size;
  logic        um, exl, erl;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] badvaddr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aerr_checker u_aerr_checker (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .req_kind_i  (req_kind),
    .req_size_i  (req_size),
    .priv_um_i   (um),
    .priv_exl_i  (exl),
    .priv_erl_i  (erl),
    .exc_valid_o (exc_valid),
    .exc_code_o  (exc_code),
    .badvaddr_o  (badvaddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] prev_bad;
    int n;
    rst_ni = 1'b0; req_valid = 0; req_addr = 32'hFFFF_FFFF;
    req_kind = 0; req_size = 0; um = 1; exl = 0; erl = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(exc_valid), 0);
    chk("R1 code", 32'(exc_code), 0);
    chk("R1 bad", badvaddr, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(exc_valid), 0);
    chk("R1 bad after release", badvaddr, 0);
    prev_bad = 32'h0;
    n = 0;
    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 4; s++)
          for (int hi = 0; hi < 2; hi++)
            for (int lo = 0; lo < 4; lo++) begin
              logic [31:0] tmp, addr;
              logic user, mis, seg, err;
              logic [4:0] code;
              string tag;
              n++;
              tmp  = n * 32'h0019_660D + 32'h3C6E_F35F;
              addr = {hi[0], tmp[28:0], lo[1:0]};
              user = p[0] & ~p[1] & ~p[2];
              if (k == 3)      mis = 1'b0;
              else if (k == 0) mis = (lo != 0);
              else if (s == 0) mis = 1'b0;
              else if (s == 1) mis = lo[0];
              else             mis = (lo != 0);
              seg  = user & hi[0] & (k != 3);
              err  = mis | seg;
              code = (k == 2) ? 5'd5 : 5'd4;
              if (k == 0 || k == 3) tag = "R8";
              else if (seg)         tag = "R4";
              else if (s == 1 || s == 0) tag = "R3";
              else                  tag = "R2";
              um = p[0]; exl = p[1]; erl = p[2];
              req_kind = 2'(k); req_size = 2'(s);
              req_addr = addr; req_valid = 1'b1;
              @(negedge clk);
              chk({tag, " R7 valid"}, 32'(exc_valid), 32'(err));
              if (err) begin
                chk("R5 code", 32'(exc_code), 32'(code));
                prev_bad = addr;
              end
              chk("R6 bad after request", badvaddr, prev_bad);
              req_valid = 1'b0;
              req_addr = addr ^ 32'h0000_0FF0;
              @(negedge clk);
              chk("R7 no request", 32'(exc_valid), 0);
              chk("R6 hold", badvaddr, prev_bad);
            end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule